// File: doc/BRIEF.md
# Tamper Monitor Security Controller

This block is the security core of a battery-backed tamper monitor. It keeps two state flags: a non-valid flag, raised whenever battery power is applied, and a security-violation flag, raised when an enabled tamper source fires. Ten digital event inputs stand in for the sensors. Each one is gated by an enable bit in a configuration register. When an enabled source fires, the block latches a sticky status bit for it and enters the failure state. While either flag is set, a stop output freezes the time and monotonic counters next to the block.

Leaving the failure state follows a fixed order. First a system reset turns a plain failure into the combined non-valid plus failure state. Software then disables every source, clears the latched event bits, clears the violation flag, and clears non-valid last. The configuration is protected by a soft lock and a hard lock. A separate failure hard lock blocks recovery altogether. Software can only set a lock bit. A system reset releases the soft lock, and only a battery reset releases the hard locks.

The register write port is a plain one-cycle strobe with a two-bit selector: 0 = configuration, 1 = control, 2 = status. All three registers are always visible on output ports.

Top module: `tamper_monitor`

## Requirements
- R1: A battery reset (`bat_rst_n` low, synchronous) sets non-valid (status bit 1), clears violation (status bit 0), and clears every latched event bit, the configuration and all lock bits. After release `status_o` reads 0x2.
- R2: An event input whose configuration bit is set latches its status bit at the next clock edge, and the violation flag is set at the same edge. Sources 0..7 map to status bits 16..23. Source 8 (time overflow) maps to status bit 2 and source 9 (monotonic overflow) to status bit 3. An event whose enable bit is clear has no effect.
- R3: Writing 1 to a latched event status bit clears it. If the same source fires in the same cycle, the set wins.
- R4: A configuration write (selector 0) has no effect while the soft lock (control bit 29) or the hard lock (control bit 30) is set.
- R5: A status write with bit 0 set clears the violation flag only if all of these hold: non-valid is set, no event status bit is latched, the configuration is all zero, and the failure hard lock is clear. Otherwise the write leaves the flag set.
- R6: A system reset (`sys_rst_n` low) taken while the violation flag is set also sets non-valid. A system reset clears the soft lock and leaves the hard locks, the configuration and the latched events unchanged.
- R7: A status write with bit 1 set clears non-valid only while the violation flag is clear.
- R8: `stop_o` is high while either flag is set. `valid_o` is high only when both flags are clear.
- R9: A control write (selector 1) can only set lock bits 16, 29 and 30 and can never clear them. The soft lock is cleared by a system or battery reset. The hard locks are cleared only by a battery reset.
- R10: While the failure hard lock (control bit 16) is set, the violation flag cannot be cleared, even when every other condition of R5 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| bat_rst_n | input | 1 | Battery power-on reset, active low, synchronous |
| sys_rst_n | input | 1 | System reset, active low, synchronous |
| evt_i | input | N_SRC | Tamper event inputs, one per source |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_addr | input | 2 | Register selector: 0 configuration, 1 control, 2 status |
| wr_data | input | DATA_W | Write data |
| cfg_o | output | N_SRC | Source enable configuration |
| ctrl_o | output | DATA_W | Control register (lock bits 16, 29, 30) |
| status_o | output | DATA_W | Status: flags, overflow and tamper event bits |
| stop_o | output | 1 | Freeze request to the time and monotonic counters |
| valid_o | output | 1 | Both flags clear |

## Verification
The bench builds the block with its default parameters: all ten sources, a 32-bit data path, and the stop output driven by either flag. With these values both overflow sources land on status bits 2 and 3 while the sensor sources use bits 16 to 23, and the lock bits at 29 and 30 fall inside the register. The bench walks the full recovery sequence and then tries each step out of order: clearing the violation with non-valid still clear, with the sources still enabled, and under the failure hard lock. It also checks that a simultaneous event and clear leaves the event bit set, and it checks which lock bits each kind of reset releases.

// File: rtl/tmon_pkg.sv
package tmon_pkg;

   typedef enum logic [1:0] {
      SEL_CFG  = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_STAT = 2'd2,
      SEL_NONE = 2'd3
   } tmon_sel_e;

   localparam int FLAG_SV_BIT   = 0;
   localparam int FLAG_NV_BIT   = 1;
   localparam int LOCK_FAIL_BIT = 16;
   localparam int LOCK_SOFT_BIT = 29;
   localparam int LOCK_HARD_BIT = 30;
   localparam int MAX_SRC       = 10;

   // sensor sources sit in the upper half, counter overflows in the low bits
   function automatic int evt_status_pos(input int src);
      return (src < 8) ? (16 + src) : (src - 6);
   endfunction

endpackage

// File: rtl/tmon_evt_latch.sv
module tmon_evt_latch #(
   parameter int N_SRC = 10
) (
   input  logic             clk,
   input  logic             bat_rst_n,
   input  logic [N_SRC-1:0] hit_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] pend_o,
   output logic             any_o
);

   logic [N_SRC-1:0] pend_q;

   always_ff @(posedge clk) begin
      if (!bat_rst_n) pend_q <= '0;
      else            pend_q <= (pend_q & ~clr_i) | hit_i;
   end

   assign pend_o = pend_q;
   assign any_o  = |pend_q;

   p_set_beats_clear_r3: assert property (@(posedge clk) disable iff (!bat_rst_n)
      (|hit_i) |=> ((pend_o & $past(hit_i)) == $past(hit_i)))
      else $error("event bit lost against clear");

   p_cleared_bit_drops_r3: assert property (@(posedge clk) disable iff (!bat_rst_n)
      (|(clr_i & ~hit_i)) |=> ((pend_o & $past(clr_i & ~hit_i)) == '0))
      else $error("write-one-clear did not clear");

endmodule

// File: rtl/tmon_lock_regs.sv
module tmon_lock_regs #(
   parameter int N_SRC  = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              bat_rst_n,
   input  logic              sys_rst_n,
   input  logic              cfg_we_i,
   input  logic              ctrl_we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [N_SRC-1:0]  cfg_o,
   output logic              soft_o,
   output logic              hard_o,
   output logic              fail_hard_o
);
   import tmon_pkg::*;

   logic [N_SRC-1:0] cfg_q;
   logic             soft_q, hard_q, fail_q;
   logic             cfg_open;

   assign cfg_open = !soft_q && !hard_q;

   // configuration and hard locks survive a system reset
   always_ff @(posedge clk) begin
      if (!bat_rst_n) begin
         cfg_q  <= '0;
         hard_q <= 1'b0;
         fail_q <= 1'b0;
      end else if (sys_rst_n) begin
         if (cfg_we_i && cfg_open) cfg_q <= wdata_i[N_SRC-1:0];
         if (ctrl_we_i) begin
            hard_q <= hard_q | wdata_i[LOCK_HARD_BIT];
            fail_q <= fail_q | wdata_i[LOCK_FAIL_BIT];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!bat_rst_n || !sys_rst_n) soft_q <= 1'b0;
      else if (ctrl_we_i)           soft_q <= soft_q | wdata_i[LOCK_SOFT_BIT];
   end

   assign cfg_o       = cfg_q;
   assign soft_o      = soft_q;
   assign hard_o      = hard_q;
   assign fail_hard_o = fail_q;

   p_cfg_frozen_r4: assert property (@(posedge clk) disable iff (!bat_rst_n)
      (soft_o || hard_o) |=> $stable(cfg_o))
      else $error("configuration changed under lock");

   p_hard_sticky_r9: assert property (@(posedge clk) disable iff (!bat_rst_n)
      hard_o |=> hard_o)
      else $error("hard lock released without battery reset");

   p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!bat_rst_n)
      fail_hard_o |=> fail_hard_o)
      else $error("failure lock released without battery reset");

   p_soft_sticky_r9: assert property (@(posedge clk) disable iff (!bat_rst_n || !sys_rst_n)
      soft_o |=> soft_o)
      else $error("soft lock released by software");

endmodule

// File: rtl/tmon_flags.sv
module tmon_flags (
   input  logic clk,
   input  logic bat_rst_n,
   input  logic sys_rst_n,
   input  logic set_sv_i,
   input  logic clr_sv_req_i,
   input  logic clr_nv_req_i,
   input  logic pend_any_i,
   input  logic cfg_zero_i,
   input  logic fail_hard_i,
   output logic nv_o,
   output logic sv_o
);

   logic nv_q, sv_q;
   logic sv_release, nv_release;

   assign sv_release = clr_sv_req_i && nv_q && !pend_any_i && cfg_zero_i && !fail_hard_i;
   assign nv_release = clr_nv_req_i && !sv_q && !set_sv_i;

   always_ff @(posedge clk) begin
      if (!bat_rst_n) begin
         nv_q <= 1'b1;
         sv_q <= 1'b0;
      end else if (!sys_rst_n) begin
         nv_q <= nv_q | sv_q;
         sv_q <= sv_q | set_sv_i;
      end else begin
         if (set_sv_i)        sv_q <= 1'b1;
         else if (sv_release) sv_q <= 1'b0;
         if (nv_release)      nv_q <= 1'b0;
      end
   end

   assign nv_o = nv_q;
   assign sv_o = sv_q;

   p_event_fails_r2: assert property (@(posedge clk) disable iff (!bat_rst_n)
      set_sv_i |=> sv_o)
      else $error("enabled event did not enter failure");

   p_sv_exit_needs_nv_r5: assert property (@(posedge clk) disable iff (!bat_rst_n)
      $fell(sv_o) |-> $past(nv_o))
      else $error("violation cleared outside combined state");

   p_nv_exit_needs_sv_clear_r7: assert property (@(posedge clk) disable iff (!bat_rst_n)
      $fell(nv_o) |-> (!$past(sv_o) && !sv_o))
      else $error("non-valid cleared with violation pending");

   p_sysrst_combined_r6: assert property (@(posedge clk) disable iff (!bat_rst_n)
      (!sys_rst_n && sv_o) |=> (nv_o && sv_o))
      else $error("system reset did not enter combined state");

   p_fail_lock_holds_r10: assert property (@(posedge clk) disable iff (!bat_rst_n)
      (fail_hard_i && sv_o) |=> sv_o)
      else $error("violation cleared under failure lock");

endmodule

// File: rtl/tamper_monitor.sv
module tamper_monitor #(
   parameter int N_SRC      = 10,
   parameter int DATA_W     = 32,
   parameter bit STOP_ON_NV = 1'b1
) (
   input  logic              clk,
   input  logic              bat_rst_n,
   input  logic              sys_rst_n,
   input  logic [N_SRC-1:0]  evt_i,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [N_SRC-1:0]  cfg_o,
   output logic [DATA_W-1:0] ctrl_o,
   output logic [DATA_W-1:0] status_o,
   output logic              stop_o,
   output logic              valid_o
);
   import tmon_pkg::*;

   generate
      if (N_SRC < 1 || N_SRC > MAX_SRC) begin : g_bad_src
         $error("N_SRC must lie in 1..10");
      end
      if (DATA_W < LOCK_HARD_BIT + 1) begin : g_bad_width
         $error("DATA_W too narrow for the lock bits");
      end
   endgenerate

   tmon_sel_e        sel;
   logic             wr_live, cfg_we, ctrl_we, stat_we;
   logic [N_SRC-1:0] cfg, hit, clr, pend;
   logic             pend_any, soft_lk, hard_lk, fail_lk, nv, sv;
   logic             unused_wdata;

   assign sel     = tmon_sel_e'(wr_addr);
   assign wr_live = wr_en && sys_rst_n;
   assign cfg_we  = wr_live && (sel == SEL_CFG);
   assign ctrl_we = wr_live && (sel == SEL_CTRL);
   assign stat_we = wr_live && (sel == SEL_STAT);
   assign hit     = evt_i & cfg;
   assign unused_wdata = ^wr_data;

   tmon_lock_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_locks (
      .clk         (clk),
      .bat_rst_n   (bat_rst_n),
      .sys_rst_n   (sys_rst_n),
      .cfg_we_i    (cfg_we),
      .ctrl_we_i   (ctrl_we),
      .wdata_i     (wr_data),
      .cfg_o       (cfg),
      .soft_o      (soft_lk),
      .hard_o      (hard_lk),
      .fail_hard_o (fail_lk)
   );

   tmon_evt_latch #(.N_SRC(N_SRC)) u_events (
      .clk       (clk),
      .bat_rst_n (bat_rst_n),
      .hit_i     (hit),
      .clr_i     (clr),
      .pend_o    (pend),
      .any_o     (pend_any)
   );

   tmon_flags u_flags (
      .clk          (clk),
      .bat_rst_n    (bat_rst_n),
      .sys_rst_n    (sys_rst_n),
      .set_sv_i     (|hit),
      .clr_sv_req_i (stat_we && wr_data[FLAG_SV_BIT]),
      .clr_nv_req_i (stat_we && wr_data[FLAG_NV_BIT]),
      .pend_any_i   (pend_any),
      .cfg_zero_i   (cfg == '0),
      .fail_hard_i  (fail_lk),
      .nv_o         (nv),
      .sv_o         (sv)
   );

   // per-source clear strobe and status placement
   always_comb begin
      status_o = '0;
      status_o[FLAG_SV_BIT] = sv;
      status_o[FLAG_NV_BIT] = nv;
      for (int s = 0; s < N_SRC; s++) begin
         clr[s] = stat_we && wr_data[evt_status_pos(s)];
         status_o[evt_status_pos(s)] = pend[s];
      end
   end

   always_comb begin
      ctrl_o = '0;
      ctrl_o[LOCK_FAIL_BIT] = fail_lk;
      ctrl_o[LOCK_SOFT_BIT] = soft_lk;
      ctrl_o[LOCK_HARD_BIT] = hard_lk;
   end

   assign cfg_o   = cfg;
   assign valid_o = !nv && !sv;

   generate
      if (STOP_ON_NV) begin : g_stop_both
         assign stop_o = nv || sv;
      end else begin : g_stop_sv
         assign stop_o = sv;
      end
   endgenerate

   p_valid_not_stopped_r8: assert property (@(posedge clk) disable iff (!bat_rst_n)
      valid_o |-> !stop_o)
      else $error("stop asserted while valid");

endmodule

// File: tb/tb_tamper_monitor.sv
module tb_tamper_monitor;

   logic        clk = 1'b0;
   logic        bat_rst_n = 1'b0;
   logic        sys_rst_n = 1'b1;
   logic [9:0]  evt_i = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [9:0]  cfg_o;
   logic [31:0] ctrl_o, status_o;
   logic        stop_o, valid_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   tamper_monitor dut (
      .clk(clk), .bat_rst_n(bat_rst_n), .sys_rst_n(sys_rst_n), .evt_i(evt_i),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cfg_o(cfg_o),
      .ctrl_o(ctrl_o), .status_o(status_o), .stop_o(stop_o), .valid_o(valid_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [9:0] m);
      @(negedge clk); evt_i = m;
      @(negedge clk); evt_i = '0;
   endtask

   task automatic sys_reset();
      @(negedge clk); sys_rst_n = 1'b0;
      repeat (2) @(negedge clk);
      sys_rst_n = 1'b1;
   endtask

   task automatic bat_reset();
      @(negedge clk); bat_rst_n = 1'b0;
      repeat (2) @(negedge clk);
      bat_rst_n = 1'b1;
   endtask

   task automatic t_power_on();
      bat_reset();
      chk("R1 status", status_o, 32'h2);
      chk("R1 cfg", {22'b0, cfg_o}, 32'h0);
      chk("R1 ctrl", ctrl_o, 32'h0);
      chk("R8 stop nv", {31'b0, stop_o}, 32'h1);
      wr(2'd2, 32'h2);
      chk("R7 nv clear", status_o, 32'h0);
      chk("R8 valid", {30'b0, valid_o, stop_o}, 32'h2);
   endtask

   task automatic t_events();
      pulse(10'h001);
      chk("R2 disabled ignored", status_o, 32'h0);
      wr(2'd0, 32'h101);
      chk("R2 cfg", {22'b0, cfg_o}, 32'h101);
      pulse(10'h100);
      chk("R2 time overflow bit2", status_o, 32'h5);
      pulse(10'h001);
      chk("R2 voltage bit16", status_o, 32'h10005);
      chk("R8 stop sv", {30'b0, valid_o, stop_o}, 32'h1);
      wr(2'd2, 32'h1);
      chk("R5 blocked nv clear", status_o, 32'h10005);
   endtask

   task automatic t_soft_lock();
      wr(2'd1, 32'h2000_0000);
      chk("R9 soft set", ctrl_o, 32'h2000_0000);
      wr(2'd0, 32'h0);
      chk("R4 soft blocks cfg", {22'b0, cfg_o}, 32'h101);
      wr(2'd1, 32'h0);
      chk("R9 no sw clear", ctrl_o, 32'h2000_0000);
      sys_reset();
      chk("R6 soft released", ctrl_o, 32'h0);
      chk("R6 combined state", status_o, 32'h10007);
      chk("R6 cfg kept", {22'b0, cfg_o}, 32'h101);
   endtask

   task automatic t_recover();
      @(negedge clk);
      evt_i = 10'h001; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h10000;
      @(negedge clk);
      evt_i = '0; wr_en = 1'b0;
      chk("R3 set wins", status_o, 32'h10007);
      wr(2'd2, 32'h10004);
      chk("R3 w1c", status_o, 32'h3);
      wr(2'd2, 32'h1);
      chk("R5 blocked cfg nonzero", status_o, 32'h3);
      wr(2'd2, 32'h2);
      chk("R7 blocked by sv", status_o, 32'h3);
      wr(2'd0, 32'h0);
      wr(2'd2, 32'h1);
      chk("R5 sv cleared", status_o, 32'h2);
      wr(2'd2, 32'h2);
      chk("R7 nv cleared", status_o, 32'h0);
      chk("R8 valid again", {30'b0, valid_o, stop_o}, 32'h2);
   endtask

   task automatic t_fail_lock();
      wr(2'd0, 32'h1);
      wr(2'd1, 32'h0001_0000);
      pulse(10'h001);
      chk("R2 fail entry", status_o, 32'h10001);
      wr(2'd0, 32'h0);
      sys_reset();
      chk("R9 fail lock kept", ctrl_o, 32'h0001_0000);
      chk("R6 combined", status_o, 32'h10003);
      wr(2'd2, 32'h10000);
      wr(2'd2, 32'h1);
      chk("R10 sv held", status_o, 32'h3);
      bat_reset();
      chk("R1 after battery", status_o, 32'h2);
      chk("R9 battery clears", ctrl_o, 32'h0);
   endtask

   task automatic t_hard_lock();
      wr(2'd1, 32'h4000_0000);
      wr(2'd0, 32'h3);
      chk("R4 hard blocks cfg", {22'b0, cfg_o}, 32'h0);
      sys_reset();
      chk("R9 hard survives sys", ctrl_o, 32'h4000_0000);
      wr(2'd0, 32'h3);
      chk("R4 still blocked", {22'b0, cfg_o}, 32'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_power_on();
      t_events();
      t_soft_lock();
      t_recover();
      t_fail_lock();
      t_hard_lock();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule